// File: doc/BRIEF.md
# Triggered Acquisition Capture Controller

This block serves one ADC channel. It takes a stream of 16-bit samples, each marked by a conversion strobe. It assembles them into a packet of fixed length, then tells a downstream round-robin sender that the packet can be collected. The sender reads the packet word by word through a small read port. It then acknowledges the packet, and that acknowledgement re-arms the controller.

The controller has two capture modes. In continuous mode packets are filled one after another without waiting for any event. In triggered mode the controller first waits for a trigger. The trigger comes from one of two sources. The internal source fires when the sample stream crosses a signed level on the way up. The external source fires on the rising edge of a pin, after that pin has been synchronised to the clock. A signed delay positions the packet relative to the trigger sample. A positive delay skips samples after the trigger before the packet starts. A negative delay brings samples from before the trigger into the head of the packet. Those earlier samples come from a circular history that is as deep as one packet.

Top module: `trig_capture_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), pkt_ready and pkt_start are both 0.
- R2: In continuous mode (trig_mode=0), a packet holds the first PKT_LEN strobed samples accepted after the arm edge, in order. Arming happens either on the first enabled clock out of the disabled state, or on the edge where pkt_ack is high while pkt_ready is high. After that acknowledgement, the next packet starts with the first sample strobed after the acknowledging edge.
- R3: A sample is taken only on a clock edge where smp_stb is 1. The value of smp_data at any other time has no effect on the packet.
- R4: With the internal source selected (trig_ext_sel=0), the trigger sample is the first sample, after arming, that is at or above trig_level (signed), where the sample before it was below trig_level. The first sample after arming never triggers.
- R5: With the external source selected (trig_ext_sel=1), a rising edge on ext_trig, held for at least two clocks, counts as a trigger. The trigger sample is the first strobed sample taken on or after the third clock edge following the edge.
- R6: When trig_delay is 0, word 0 of the packet is the trigger sample.
- R7: When trig_delay is d>0 (signed), word 0 of the packet is the d-th sample after the trigger sample.
- R8: When trig_delay is -m, word 0 of the packet is the sample N places before the trigger sample. N is the smallest of three values: m, the number of samples accepted since arming before the trigger, and PKT_LEN-1.
- R9: When a packet completes, pkt_start is high for exactly one cycle and pkt_ready rises in the same cycle. pkt_ready stays high until pkt_ack. rd_data shows packet word rd_addr one clock after rd_addr is presented.
- R10: While pkt_ready is high, samples, internal crossings and external edges are all ignored. The packet contents do not change and no further pkt_start is produced.
- R11: trig_mode, trig_ext_sel, trig_level and trig_delay are latched at the arm edge. Changes made while a capture is under way do not affect that capture.
- R12: While ch_en is 0 the controller captures nothing and raises neither pkt_ready nor pkt_start. Dropping ch_en abandons any partial or pending packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_en | input | 1 | Channel enable |
| trig_mode | input | 1 | 0 continuous, 1 triggered |
| trig_ext_sel | input | 1 | 0 internal level crossing, 1 external pin |
| trig_level | input | DW | Signed internal trigger level |
| trig_delay | input | DLY_W | Signed trigger delay in samples |
| ext_trig | input | 1 | Asynchronous external trigger |
| smp_data | input | DW | Sample value |
| smp_stb | input | 1 | Conversion strobe qualifying smp_data |
| rd_addr | input | AW | Word index within the ready packet |
| rd_data | output | DW | Packet word, one clock after rd_addr |
| pkt_start | output | 1 | One-cycle pulse on packet completion |
| pkt_ready | output | 1 | Packet held and readable |
| pkt_ack | input | 1 | Packet consumed, re-arm |

## Verification
The embedded properties make several assumptions about the neighbours. They assume the sender holds rd_addr steady while it expects a repeated word. They assume pkt_ack is raised only to release a ready packet. They assume an external trigger pulse lasts at least two clocks. The stimulus follows these rules: it changes rd_addr only at falling edges and only to step through a packet, it raises pkt_ack only after pkt_ready is seen, and it holds every ext_trig pulse for two clocks with three idle clocks after it. Between strobes, smp_data carries random junk, and every accepted sample carries a unique ramp value. This lets each packet word be traced back to the exact sample that produced it.

// File: rtl/cap_pkg.sv
// Shared types for the capture controller.
package cap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // disabled, nothing captured
        ST_PRE,    // writing history, watching for a trigger
        ST_HOLD,   // positive delay countdown after trigger
        ST_FILL,   // packet being filled
        ST_DONE    // packet complete, waiting for acknowledge
    } cap_state_e;
endpackage

// File: rtl/cap_edge_sync.sv
// Two-flop synchroniser plus edge register for an asynchronous trigger pin.
// Produces a one-cycle pulse on each rising edge. It assumes input pulses
// last at least two clocks.
module cap_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [2:0] sh;

    // shift the pin through two sync flops and one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], async_in};
    end

    assign rise = sh[1] & ~sh[2];

    a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/cap_trig_detect.sv
// Trigger qualifier. It flags the strobed sample that is the trigger, either
// by a signed upward level crossing or by a pending external edge. The
// caller clears it at every arm. Edges seen while not watching are dropped.
module cap_trig_detect #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 watch,
    input  logic                 stb,
    input  logic signed [DW-1:0] data,
    input  logic signed [DW-1:0] level,
    input  logic                 use_ext,
    input  logic                 ext_rise,
    output logic                 hit
);
    logic signed [DW-1:0] prev;
    logic                 prev_ok;
    logic                 ext_pend;
    logic                 int_hit;

    assign int_hit = prev_ok && (prev < level) && (data >= level);
    assign hit     = watch && stb && (use_ext ? (ext_pend || ext_rise) : int_hit);

    // remember the previous sample and any external edge seen while armed
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prev     <= '0;
            prev_ok  <= 1'b0;
            ext_pend <= 1'b0;
        end else begin
            if (watch && stb) begin
                prev    <= data;
                prev_ok <= 1'b1;
            end
            if (hit)                   ext_pend <= 1'b0;
            else if (watch && ext_rise) ext_pend <= 1'b1;
        end
    end

    a_r4_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !use_ext) |=> !hit);
endmodule

// File: rtl/cap_ring_buf.sv
// Circular sample store, one write port and one registered read port.
// The depth is a power of two, so the pointers wrap naturally.
module cap_ring_buf #(
    parameter int DW    = 16,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // store one sample per write strobe
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // registered read for the sender
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[raddr];
    end
endmodule

// File: rtl/trig_capture_ctrl.sv
// Per-channel capture controller. One circular buffer holds both the
// pre-trigger history and the packet. The packet is PKT_LEN consecutive
// entries from start_q, and the buffer is frozen while the packet waits for
// pkt_ack. Configuration is latched at each arm. PKT_LEN must be a power of
// two and at least 2, and DLY_W must exceed $clog2(PKT_LEN).
module trig_capture_ctrl #(
    parameter int DW      = 16,
    parameter int PKT_LEN = 1024,
    parameter int DLY_W   = 16,
    localparam int AW     = $clog2(PKT_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_en,
    input  logic             trig_mode,
    input  logic             trig_ext_sel,
    input  logic [DW-1:0]    trig_level,
    input  logic [DLY_W-1:0] trig_delay,
    input  logic             ext_trig,
    input  logic [DW-1:0]    smp_data,
    input  logic             smp_stb,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             pkt_start,
    output logic             pkt_ready,
    input  logic             pkt_ack
);
    import cap_pkg::*;

    localparam int CW = AW + 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(PKT_LEN - 1);

    cap_state_e       st;
    logic             mode_q, ext_q;
    logic [DW-1:0]    level_q;
    logic [DLY_W-1:0] dly_q;
    logic [AW-1:0]    wp, start_q, col, n_back;
    logic [CW-1:0]    fc;
    logic [DLY_W-1:0] hold, mag;
    logic             capturing, we, arm, ext_rise, hit, dly_neg, dly_pos;

    assign capturing = (st == ST_PRE) || (st == ST_HOLD) || (st == ST_FILL);
    assign we        = ch_en && capturing && smp_stb;
    assign arm       = ch_en && ((st == ST_IDLE) || (st == ST_DONE && pkt_ack));
    assign pkt_ready = (st == ST_DONE);
    assign dly_neg   = dly_q[DLY_W-1];
    assign dly_pos   = !dly_neg && (dly_q != '0);
    assign mag       = dly_neg ? (~dly_q + 1'b1) : '0;

    // number of history samples to place ahead of the trigger sample
    always_comb begin
        if (32'(mag) < 32'(col)) n_back = AW'(mag);
        else                     n_back = col;
    end

    cap_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_trig),
        .rise     (ext_rise)
    );

    cap_trig_detect #(.DW(DW)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (arm),
        .watch    (ch_en && st == ST_PRE),
        .stb      (smp_stb),
        .data     (smp_data),
        .level    (level_q),
        .use_ext  (ext_q),
        .ext_rise (ext_rise),
        .hit      (hit)
    );

    cap_ring_buf #(.DW(DW), .DEPTH(PKT_LEN)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (wp),
        .wdata (smp_data),
        .raddr (start_q + rd_addr),
        .rdata (rd_data)
    );

    // capture sequencing: arm, watch, hold, fill, wait for acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            mode_q    <= 1'b0;
            ext_q     <= 1'b0;
            level_q   <= '0;
            dly_q     <= '0;
            wp        <= '0;
            start_q   <= '0;
            fc        <= '0;
            col       <= '0;
            hold      <= '0;
            pkt_start <= 1'b0;
        end else begin
            pkt_start <= 1'b0;
            if (we) wp <= wp + 1'b1;
            if (!ch_en) begin
                st <= ST_IDLE;
            end else if (arm) begin
                mode_q  <= trig_mode;
                ext_q   <= trig_ext_sel;
                level_q <= trig_level;
                dly_q   <= trig_delay;
                col     <= '0;
                fc      <= '0;
                start_q <= wp;
                st      <= trig_mode ? ST_PRE : ST_FILL;
            end else if (smp_stb) begin
                case (st)
                    ST_PRE: begin
                        if (hit && dly_pos) begin
                            hold <= dly_q;
                            st   <= ST_HOLD;
                        end else if (hit) begin
                            start_q <= wp - n_back;
                            fc      <= CW'(n_back) + 1'b1;
                            if (n_back == LAST_IDX) begin
                                st        <= ST_DONE;
                                pkt_start <= 1'b1;
                            end else begin
                                st <= ST_FILL;
                            end
                        end else if (col != LAST_IDX) begin
                            col <= col + 1'b1;
                        end
                    end
                    ST_HOLD: begin
                        if (hold == DLY_W'(1)) begin
                            start_q <= wp;
                            fc      <= CW'(1);
                            st      <= ST_FILL;
                        end else begin
                            hold <= hold - 1'b1;
                        end
                    end
                    ST_FILL: begin
                        fc <= fc + 1'b1;
                        if (fc == CW'(PKT_LEN - 1)) begin
                            st        <= ST_DONE;
                            pkt_start <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r9_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |=> !pkt_start);
    a_r9_pulse_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |-> pkt_ready);
    a_r9_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_ready && !pkt_ack && ch_en) |=> pkt_ready);
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_ready && $past(pkt_ready) && $stable(rd_addr)) |=> $stable(rd_data));
    a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> (!pkt_ready && !pkt_start));
    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL) |-> (fc < CW'(PKT_LEN)));
endmodule

// File: tb/trig_capture_ctrl_tb.sv
// Self-checking bench: ramp samples with unique values, random gaps and junk
// between strobes, directed corners plus seeded random trigger cases.
module trig_capture_ctrl_tb;
    localparam int L = 16;

    logic        clk = 1'b0;
    logic        rst_n, ch_en, trig_mode, ext_sel, ext_trig, smp_stb, pkt_ack;
    logic [15:0] trig_level, trig_delay, smp_data, rd_data;
    logic [3:0]  rd_addr;
    logic        pkt_start, pkt_ready;
    int          errors = 0, checks = 0, nstart = 0;

    always #5 clk = ~clk;

    trig_capture_ctrl #(.DW(16), .PKT_LEN(L), .DLY_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .trig_mode(trig_mode),
        .trig_ext_sel(ext_sel), .trig_level(trig_level), .trig_delay(trig_delay),
        .ext_trig(ext_trig), .smp_data(smp_data), .smp_stb(smp_stb),
        .rd_addr(rd_addr), .rd_data(rd_data), .pkt_start(pkt_start),
        .pkt_ready(pkt_ready), .pkt_ack(pkt_ack)
    );

    always @(negedge clk) if (pkt_start === 1'b1) nstart++;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(int v);
        smp_data = 16'(v);
        smp_stb  = 1'b1;
        @(negedge clk);
        smp_stb  = 1'b0;
        smp_data = 16'($urandom);
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    task automatic ext_pulse();
        ext_trig = 1'b1;
        idle(2);
        ext_trig = 1'b0;
        idle(3);
    endtask

    task automatic ramp(int v0, int maxn, int ext_k);
        for (int k = 0; k < maxn && !pkt_ready; k++) begin
            if (k == ext_k) ext_pulse();
            put(v0 + k);
        end
    endtask

    task automatic rearm(bit m, bit s, int lvl, int d);
        trig_mode  = m;
        ext_sel    = s;
        trig_level = 16'(lvl);
        trig_delay = 16'(d);
        pkt_ack    = 1'b1;
        @(negedge clk);
        pkt_ack    = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_pkt(int base, string req);
        int bad = -1;
        logic [15:0] got = '0, exp = '0;
        chk(pkt_ready == 1'b1, req, "packet ready", int'(pkt_ready), 1);
        for (int i = 0; i < L; i++) begin
            rd_addr = 4'(i);
            @(negedge clk);
            if (bad < 0 && rd_data !== 16'(base + i)) begin
                bad = i;
                got = rd_data;
                exp = 16'(base + i);
            end
        end
        chk(bad < 0, req, $sformatf("packet word %0d", bad), int'($signed(got)), int'($signed(exp)));
    endtask

    function automatic int exp_start(int trig_val, int coll, int d);
        int n;
        if (d >= 0) return trig_val + d;
        n = -d;
        if (n > coll) n = coll;
        if (n > L - 1) n = L - 1;
        return trig_val - n;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n0, lvl, pre, d, v0, ek;
        void'($urandom(32'd7));
        rst_n = 0; ch_en = 0; trig_mode = 0; ext_sel = 0; ext_trig = 0;
        smp_stb = 0; pkt_ack = 0; trig_level = 0; trig_delay = 0;
        smp_data = 0; rd_addr = 0;
        idle(4);
        rst_n = 1;
        idle(1);
        chk(pkt_ready == 1'b0, "R1", "ready after reset", int'(pkt_ready), 0);
        chk(pkt_start == 1'b0, "R1", "start after reset", int'(pkt_start), 0);

        // R2 R3: continuous packet, junk between strobes
        ch_en = 1;
        idle(1);
        ramp(1000, 40, -1);
        check_pkt(1000, "R2 R3");
        chk(nstart == 1, "R9", "start pulses", nstart, 1);
        // R2: back to back after acknowledge
        rearm(0, 0, 0, 0);
        chk(pkt_ready == 1'b0, "R9", "ready cleared by ack", int'(pkt_ready), 0);
        ramp(2000, 40, -1);
        check_pkt(2000, "R2");
        chk(nstart == 2, "R9", "start pulses", nstart, 2);

        // R4 R6: internal crossing at 50, delay 0, 10 samples collected
        rearm(1, 0, 50, 0);  ramp(40, 60, -1); check_pkt(50, "R4 R6");
        rearm(1, 0, 50, 3);  ramp(40, 60, -1); check_pkt(53, "R7");
        rearm(1, 0, 50, -4); ramp(40, 60, -1); check_pkt(46, "R8");
        // R8 clamp to collected, then to PKT_LEN-1
        rearm(1, 0, 50, -30); ramp(40, 60, -1); check_pkt(40, "R8 clamp collected");
        rearm(1, 0, 50, -30); ramp(30, 60, -1); check_pkt(35, "R8 clamp length");

        // R5: external trigger before sample 7
        rearm(1, 1, 50, 0);  ramp(500, 60, 7); check_pkt(507, "R5");
        rearm(1, 1, 50, -5); ramp(600, 60, 7); check_pkt(602, "R5 R8");

        // R4: no crossing while values stay above, first sample never fires
        rearm(1, 0, 50, 0);
        for (int k = 0; k < 20; k++) put(100 + k);
        chk(pkt_ready == 1'b0, "R4", "no trigger without crossing", int'(pkt_ready), 0);
        put(10);
        ramp(60, 40, -1);
        check_pkt(60, "R4");

        // R10: stimulus while ready is ignored
        n0 = nstart;
        ext_pulse(); put(0); put(70); ext_pulse(); put(5); put(90);
        chk(pkt_ready == 1'b1, "R10", "still ready", int'(pkt_ready), 1);
        chk(nstart == n0, "R10", "no extra start", nstart, n0);
        check_pkt(60, "R10");

        // R11: configuration change mid-capture has no effect
        rearm(1, 0, 50, 0);
        put(40); put(41); put(42);
        trig_level = 16'd1000; trig_delay = 16'd5; ext_sel = 1;
        ramp(43, 60, -1);
        check_pkt(50, "R11");

        // R12: disabled channel captures nothing
        ch_en = 0;
        idle(2);
        n0 = nstart;
        chk(pkt_ready == 1'b0, "R12", "ready dropped on disable", int'(pkt_ready), 0);
        trig_mode = 1; ext_sel = 0; trig_level = 16'd50; trig_delay = 0;
        ramp(40, 40, 5);
        chk(pkt_ready == 1'b0, "R12", "no ready while disabled", int'(pkt_ready), 0);
        chk(nstart == n0, "R12", "no start while disabled", nstart, n0);
        trig_mode = 0;
        ch_en = 1;
        idle(1);
        ramp(3000, 40, -1);
        check_pkt(3000, "R12 R2");

        // random internal cases: R6 R7 R8
        for (int it = 0; it < 8; it++) begin
            lvl = int'($urandom_range(0, 200)) - 100;
            pre = int'($urandom_range(1, 20));
            d   = int'($urandom_range(0, 24)) - 12;
            rearm(1, 0, lvl, d);
            ramp(lvl - pre, pre + L + 20, -1);
            check_pkt(exp_start(lvl, pre, d), "R6 R7 R8 random");
        end
        // random external cases: R5
        for (int it = 0; it < 4; it++) begin
            v0 = int'($urandom_range(0, 4000));
            ek = int'($urandom_range(2, 10));
            d  = int'($urandom_range(0, 16)) - 8;
            rearm(1, 1, 0, d);
            ramp(v0, ek + L + 20, ek);
            check_pkt(exp_start(v0 + ek, ek, d), "R5 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule